// File: doc/BRIEF.md
# Receive Ring Buffer Packet Writer

This block takes received Ethernet frames as a byte stream and deposits them into a circular receive area of local RAM. The area is split into 256-byte pages. Software sets the first page of the ring and the page just past its last usable page. It also owns a boundary page that marks how far it has consumed the ring. The block owns a current page that marks where the next frame will land. Each stored frame occupies a whole number of pages. It begins with a 4-byte descriptor holding a status byte, the page of the following frame and the stored length. The frame bytes come next, zero-extended to the minimum Ethernet size.

A frame is taken only if the receiver is not halted and the ring still has room for a maximum-size frame. Frame bytes are written as they arrive, wrapping from the end of the ring back to its start. Padding follows, and the descriptor is written last, once the length is known. The current page then moves to the link page and a sticky receive flag is raised for the host. Software may load the current page itself, but only while no frame is in progress.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset `busy`, `ramWe` and `rxIrq` are 0 and `curPage` is 0.
- R2: A frame whose first byte (`rxValid` and `rxSof` high) arrives while `stopMode` is 1 produces no RAM write, no `busy`, no change of `curPage` and no `rxIrq`.
- R3: With current page C, boundary page B and ring size S = stop − start pages, free pages are B − C when C < B, and otherwise S − (C − B). A frame is dropped without any write when free pages × 256 is below 1518 bytes, which means fewer than 6 pages.
- R4: Byte k of an accepted frame (k from 0) is written to address C·256 + 4 + k. Any address at or past stop·256 is pulled back by S·256, so data wraps from the end of the ring to its start.
- R5: A frame of L < 60 bytes is stored as 60 bytes, with bytes L..59 written as 0x00. The stored length is P = max(L, 60).
- R6: The descriptor occupies addresses C·256 + 0..3 and holds, in this order: the status byte, the link page, (P + 4) low byte, and (P + 4) high byte.
- R7: The status byte is 0x01. It is 0x21 when bit 0 of the frame's first byte is 1.
- R8: The link page is C + ceil((P + 8) / 256). When that value is at or beyond the stop page, S is subtracted from it.
- R9: When the descriptor is complete, `curPage` takes the link page and `rxIrq` becomes 1 on the same clock edge on which `busy` falls. A pulse on `irqClr` returns `rxIrq` to 0.
- R10: With bytes streamed back to back, `busy` is high for exactly P + 3 cycles after the edge that takes the first byte, and exactly P + 4 RAM writes occur. While `busy` is high a new frame start is ignored. While idle, bytes without `rxSof` are ignored.
- R11: `curPgWrEn` loads `curPage` from `curPgWrData` only while idle; during a frame it has no effect. A frame start in the same cycle as an accepted host load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopMode | input | 1 | Receiver halted; new frames dropped |
| startPage | input | 8 | First page of the ring |
| stopPage | input | 8 | Page one past the last ring page |
| boundPage | input | 8 | Software boundary page |
| curPgWrEn | input | 1 | Host load strobe for the current page |
| curPgWrData | input | 8 | Host value for the current page |
| irqClr | input | 1 | Clears the receive flag |
| rxValid | input | 1 | Byte valid on rxData |
| rxSof | input | 1 | Byte is the first of a frame |
| rxEof | input | 1 | Byte is the last of a frame |
| rxData | input | 8 | Received byte |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 16 | RAM byte address |
| ramData | output | 8 | RAM write data |
| busy | output | 1 | Frame being stored |
| curPage | output | 8 | Current page pointer |
| rxIrq | output | 1 | Sticky frame-received flag |

## Verification
The RAM port is registered, so the write for a byte presented in one cycle shows on the port after the next edge. The bench model captures it one edge later again, and memory is checked only two cycles after `busy` has fallen. `busy`, `curPage` and `rxIrq` change on the same edge that ends the last descriptor write. `busy` is therefore counted on every falling edge from the first one after the start byte is taken, and the count is compared with P + 3. Dropped and ignored stimuli get a quiet window longer than the longest possible padding phase. After it, the write counter, `curPage` and `rxIrq` are compared at the ports.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAD,
    ST_HDR
  } ringState_t;

  typedef struct packed {
    logic first;   // first byte of an accepted frame
    logic dataWr;  // write an incoming byte
    logic padWr;   // write a zero pad byte
    logic hdrWr;   // write one descriptor byte
    logic commit;  // advance current page, raise flag
  } ringStrobe_t;

endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  input  logic        stopMode,
  input  logic        curPgWrEn,
  input  logic        roomOk,
  input  logic        lenShort,
  input  logic        padDone,
  input  logic        hdrLast,
  output ringStrobe_t strobe,
  output logic        busy
);

  ringState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (rxValid && rxSof && !stopMode && roomOk && !curPgWrEn) begin
          strobe.first  = 1'b1;
          strobe.dataWr = 1'b1;
          // a one-byte frame is always short of the minimum
          stateNext     = rxEof ? ST_PAD : ST_DATA;
        end
      end
      ST_DATA: begin
        if (rxValid) begin
          strobe.dataWr = 1'b1;
          if (rxEof) stateNext = lenShort ? ST_PAD : ST_HDR;
        end
      end
      ST_PAD: begin
        strobe.padWr = 1'b1;
        if (padDone) stateNext = ST_HDR;
      end
      ST_HDR: begin
        strobe.hdrWr = 1'b1;
        if (hdrLast) begin
          strobe.commit = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 12,
  parameter int MIN_LEN   = 60,
  parameter int MAX_FRAME = 1514
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ringStrobe_t               strobe,
  input  logic [7:0]                rxData,
  input  logic [PAGE_W-1:0]         startPage,
  input  logic [PAGE_W-1:0]         stopPage,
  input  logic [PAGE_W-1:0]         boundPage,
  input  logic                      curPgWrEn,
  input  logic [PAGE_W-1:0]         curPgWrData,
  input  logic                      hostIdle,
  input  logic                      irqClr,
  output logic                      roomOk,
  output logic                      lenShort,
  output logic                      padDone,
  output logic                      hdrLast,
  output logic                      ramWe,
  output logic [PAGE_W+OFF_W-1:0]   ramAddr,
  output logic [7:0]                ramData,
  output logic [PAGE_W-1:0]         curPage,
  output logic                      rxIrq
);

  localparam int ADDR_W     = PAGE_W + OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int NEED_PAGES = (MAX_FRAME + 4 + PAGE_BYTES - 1) / PAGE_BYTES;
  localparam int SPAN_W     = LEN_W + 1;
  localparam int SUM_W      = ((PAGE_W > SPAN_W) ? PAGE_W : SPAN_W) + 1;
  localparam int TOT_W      = 16;

  logic [PAGE_W-1:0] curPageQ;
  logic [ADDR_W-1:0] wrAddr;
  logic [LEN_W-1:0]  lenCnt;
  logic              mcastQ;
  logic [1:0]        hdrIdx;
  logic              irqQ;
  logic              weQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;

  // free space, counted in whole pages
  logic [PAGE_W:0] ringPages, usedPages, freePages;
  always_comb begin
    ringPages = {1'b0, stopPage} - {1'b0, startPage};
    usedPages = {1'b0, curPageQ} - {1'b0, boundPage};
    if (curPageQ < boundPage)       freePages = {1'b0, boundPage} - {1'b0, curPageQ};
    else if (ringPages >= usedPages) freePages = ringPages - usedPages;
    else                             freePages = '0;
  end
  assign roomOk = (freePages >= (PAGE_W+1)'(NEED_PAGES));

  // link page for the frame being stored
  logic [SPAN_W-1:0] spanBytes;
  logic [SUM_W-1:0]  nextSum;
  logic [PAGE_W-1:0] nextPage;
  always_comb begin
    spanBytes = SPAN_W'(lenCnt) + SPAN_W'(8 + PAGE_BYTES - 1);
    nextSum   = SUM_W'(curPageQ) + SUM_W'(spanBytes >> OFF_W);
    nextPage  = (nextSum >= SUM_W'(stopPage)) ? PAGE_W'(nextSum - SUM_W'(ringPages))
                                              : PAGE_W'(nextSum);
  end

  logic [TOT_W-1:0] totalLen;
  logic [7:0]       statusByte;
  assign totalLen   = TOT_W'(lenCnt) + TOT_W'(4);
  assign statusByte = mcastQ ? 8'h21 : 8'h01;

  // address and data selection for this cycle's write
  logic [ADDR_W-1:0] selAddr, incAddr, bumpAddr;
  logic [7:0]        hdrByte, selData;
  always_comb begin
    if (strobe.first)      selAddr = {curPageQ, OFF_W'(4)};
    else if (strobe.hdrWr) selAddr = {curPageQ, {(OFF_W-2){1'b0}}, hdrIdx};
    else                   selAddr = wrAddr;
    incAddr  = selAddr + ADDR_W'(1);
    bumpAddr = (incAddr == {stopPage, {OFF_W{1'b0}}}) ? {startPage, {OFF_W{1'b0}}} : incAddr;
    unique case (hdrIdx)
      2'd0:    hdrByte = statusByte;
      2'd1:    hdrByte = 8'(nextPage);
      2'd2:    hdrByte = totalLen[7:0];
      default: hdrByte = totalLen[15:8];
    endcase
    if (strobe.hdrWr)      selData = hdrByte;
    else if (strobe.padWr) selData = 8'h00;
    else                   selData = rxData;
  end

  assign lenShort = (lenCnt + LEN_W'(1)) < LEN_W'(MIN_LEN);
  assign padDone  = (lenCnt == LEN_W'(MIN_LEN - 1));
  assign hdrLast  = (hdrIdx == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPageQ <= '0;
      wrAddr   <= '0;
      lenCnt   <= '0;
      mcastQ   <= 1'b0;
      hdrIdx   <= '0;
      irqQ     <= 1'b0;
      weQ      <= 1'b0;
      addrQ    <= '0;
      dataQ    <= '0;
    end else begin
      weQ   <= strobe.dataWr | strobe.padWr | strobe.hdrWr;
      addrQ <= selAddr;
      dataQ <= selData;
      if (strobe.dataWr | strobe.padWr) wrAddr <= bumpAddr;
      if (strobe.first) begin
        lenCnt <= LEN_W'(1);
        mcastQ <= rxData[0];
        hdrIdx <= '0;
      end else if (strobe.dataWr | strobe.padWr) begin
        lenCnt <= lenCnt + LEN_W'(1);
      end
      if (strobe.hdrWr) hdrIdx <= hdrIdx + 2'd1;
      if (strobe.commit)                curPageQ <= nextPage;
      else if (curPgWrEn && hostIdle)   curPageQ <= curPgWrData;
      if (strobe.commit)  irqQ <= 1'b1;
      else if (irqClr)    irqQ <= 1'b0;
    end
  end

  assign ramWe   = weQ;
  assign ramAddr = addrQ;
  assign ramData = dataQ;
  assign curPage = curPageQ;
  assign rxIrq   = irqQ;

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 12,
  parameter int MIN_LEN   = 60,
  parameter int MAX_FRAME = 1514
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stopMode,
  input  logic [PAGE_W-1:0]       startPage,
  input  logic [PAGE_W-1:0]       stopPage,
  input  logic [PAGE_W-1:0]       boundPage,
  input  logic                    curPgWrEn,
  input  logic [PAGE_W-1:0]       curPgWrData,
  input  logic                    irqClr,
  input  logic                    rxValid,
  input  logic                    rxSof,
  input  logic                    rxEof,
  input  logic [7:0]              rxData,
  output logic                    ramWe,
  output logic [PAGE_W+OFF_W-1:0] ramAddr,
  output logic [7:0]              ramData,
  output logic                    busy,
  output logic [PAGE_W-1:0]       curPage,
  output logic                    rxIrq
);

  ringStrobe_t strobe;
  logic roomOk, lenShort, padDone, hdrLast;

  rx_ring_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .rxSof    (rxSof),
    .rxEof    (rxEof),
    .stopMode (stopMode),
    .curPgWrEn(curPgWrEn),
    .roomOk   (roomOk),
    .lenShort (lenShort),
    .padDone  (padDone),
    .hdrLast  (hdrLast),
    .strobe   (strobe),
    .busy     (busy)
  );

  rx_ring_dp #(
    .PAGE_W   (PAGE_W),
    .OFF_W    (OFF_W),
    .LEN_W    (LEN_W),
    .MIN_LEN  (MIN_LEN),
    .MAX_FRAME(MAX_FRAME)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxData     (rxData),
    .startPage  (startPage),
    .stopPage   (stopPage),
    .boundPage  (boundPage),
    .curPgWrEn  (curPgWrEn),
    .curPgWrData(curPgWrData),
    .hostIdle   (!busy),
    .irqClr     (irqClr),
    .roomOk     (roomOk),
    .lenShort   (lenShort),
    .padDone    (padDone),
    .hdrLast    (hdrLast),
    .ramWe      (ramWe),
    .ramAddr    (ramAddr),
    .ramData    (ramData),
    .curPage    (curPage),
    .rxIrq      (rxIrq)
  );

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    stopMode,
  input logic [PAGE_W-1:0]       startPage,
  input logic [PAGE_W-1:0]       stopPage,
  input logic                    busy,
  input logic                    ramWe,
  input logic [PAGE_W+OFF_W-1:0] ramAddr,
  input logic [PAGE_W-1:0]       curPage,
  input logic                    rxIrq
);

  p_stop_keeps_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopMode) |=> !busy);

  p_write_inside_ring_r4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr >= {startPage, {OFF_W{1'b0}}} && ramAddr < {stopPage, {OFF_W{1'b0}}}));

  p_flag_with_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> $fell(busy));

  p_write_only_in_frame_r10: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (busy || $fell(busy)));

  p_page_frozen_in_frame_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curPage));

endmodule

bind rx_ring_writer rx_ring_writer_chk #(
  .PAGE_W(PAGE_W),
  .OFF_W (OFF_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .stopMode (stopMode),
  .startPage(startPage),
  .stopPage (stopPage),
  .busy     (busy),
  .ramWe    (ramWe),
  .ramAddr  (ramAddr),
  .curPage  (curPage),
  .rxIrq    (rxIrq)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;

  localparam int START_PG = 2;
  localparam int STOP_PG  = 10;
  localparam int RING_PG  = STOP_PG - START_PG;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stopMode = 1'b0;
  logic [7:0]  startPage = 8'(START_PG);
  logic [7:0]  stopPage = 8'(STOP_PG);
  logic [7:0]  boundPage = 8'd0;
  logic        curPgWrEn = 1'b0;
  logic [7:0]  curPgWrData = 8'd0;
  logic        irqClr = 1'b0;
  logic        rxValid = 1'b0;
  logic        rxSof = 1'b0;
  logic        rxEof = 1'b0;
  logic [7:0]  rxData = 8'd0;
  logic        ramWe;
  logic [15:0] ramAddr;
  logic [7:0]  ramData;
  logic        busy;
  logic [7:0]  curPage;
  logic        rxIrq;

  int errors = 0;
  int checks = 0;
  int wrCount = 0;
  int expCur = 0;
  logic [7:0] mem [0:4095];

  always #10 clk = ~clk;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rstN(rstN), .stopMode(stopMode), .startPage(startPage),
    .stopPage(stopPage), .boundPage(boundPage), .curPgWrEn(curPgWrEn),
    .curPgWrData(curPgWrData), .irqClr(irqClr), .rxValid(rxValid),
    .rxSof(rxSof), .rxEof(rxEof), .rxData(rxData), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData), .busy(busy), .curPage(curPage),
    .rxIrq(rxIrq)
  );

  always @(posedge clk) begin
    if (ramWe) begin
      mem[ramAddr[11:0]] <= ramData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 7 + k * 13) & 255);
  endfunction

  function automatic int linkPage(input int cur, input int p);
    int n;
    n = cur + (p + 8 + 255) / 256;
    if (n >= STOP_PG) n -= RING_PG;
    return n;
  endfunction

  task automatic clearRx();
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0; rxData = 8'd0;
  endtask

  task automatic sendFrame(input int len, input int seed, input bit inject, input bit poke);
    int busyCnt, w0, p, base, nxt, a, bad;
    logic [7:0] e;
    busyCnt = 0; bad = 0;
    p = (len < 60) ? 60 : len;
    w0 = wrCount;
    base = expCur * 256;
    nxt = linkPage(expCur, p);
    @(negedge clk);
    boundPage = 8'(expCur);
    for (int i = 0; i < len; i++) begin
      if (i > 0) begin
        @(negedge clk);
        if (busy) busyCnt++;
      end
      rxValid = 1'b1; rxSof = (i == 0); rxEof = (i == len - 1); rxData = pat(seed, i);
    end
    @(negedge clk);
    if (busy) busyCnt++;
    if (inject) begin
      rxValid = 1'b1; rxSof = 1'b1; rxEof = 1'b1; rxData = 8'h55;
    end else clearRx();
    curPgWrEn = poke; curPgWrData = 8'h07;
    @(negedge clk);
    if (busy) busyCnt++;
    clearRx();
    curPgWrEn = 1'b0;
    while (busy) begin
      @(negedge clk);
      if (busy) busyCnt++;
    end
    repeat (2) @(negedge clk);
    check("R10 busy cycles", busyCnt, p + 3);
    check("R10 write count", wrCount - w0, p + 4);
    e = pat(seed, 0);
    check("R7 status byte", int'(mem[base]), e[0] ? 32'h21 : 32'h01);
    check("R6 R8 link page", int'(mem[base + 1]), nxt);
    check("R6 length low", int'(mem[base + 2]), (p + 4) & 255);
    check("R6 length high", int'(mem[base + 3]), (p + 4) >> 8);
    for (int k = 0; k < p; k++) begin
      a = base + 4 + k;
      if (a >= STOP_PG * 256) a -= RING_PG * 256;
      e = (k < len) ? pat(seed, k) : 8'h00;
      if (mem[a] !== e) bad++;
    end
    check("R4 R5 stored bytes mismatching", bad, 0);
    check("R9 current page", int'(curPage), nxt);
    check("R9 flag set", int'(rxIrq), 1);
    expCur = nxt;
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    check("R9 flag cleared", int'(rxIrq), 0);
  endtask

  task automatic sendDropped(input int len, input string req);
    int w0, seen;
    w0 = wrCount; seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (busy) seen++;
      rxValid = 1'b1; rxSof = (i == 0); rxEof = (i == len - 1); rxData = pat(len, i);
    end
    @(negedge clk);
    clearRx();
    repeat (70) begin
      @(negedge clk);
      if (busy) seen++;
    end
    check({req, " writes"}, wrCount - w0, 0);
    check({req, " busy seen"}, seen, 0);
    check({req, " page kept"}, int'(curPage), expCur);
    check({req, " flag low"}, int'(rxIrq), 0);
  endtask

  task automatic hostSet(input int v);
    @(negedge clk);
    curPgWrEn = 1'b1; curPgWrData = 8'(v);
    @(negedge clk);
    curPgWrEn = 1'b0;
    check("R11 host load while idle", int'(curPage), v);
    expCur = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 ramWe", int'(ramWe), 0);
    check("R1 flag", int'(rxIrq), 0);
    check("R1 page", int'(curPage), 0);
    rstN = 1'b1;
    hostSet(START_PG);

    // idle bytes without a frame start
    w0 = wrCount;
    repeat (3) begin
      @(negedge clk);
      rxValid = 1'b1; rxSof = 1'b0; rxData = 8'h33;
    end
    @(negedge clk);
    clearRx();
    repeat (3) @(negedge clk);
    check("R10 idle non-start bytes writes", wrCount - w0, 0);
    check("R10 idle non-start bytes busy", int'(busy), 0);

    // length sweep around padding and page rounding
    for (int len = 1; len <= 70; len++) sendFrame(len, len, 1'b0, 1'b0);
    for (int len = 244; len <= 253; len++) sendFrame(len, len + 3, 1'b0, 1'b0);
    sendFrame(1000, 11, 1'b0, 1'b0);
    sendFrame(1514, 12, 1'b0, 1'b0);

    // explicit wrap from the last ring page
    hostSet(STOP_PG - 1);
    sendFrame(300, 5, 1'b0, 1'b0);

    // halted receiver
    stopMode = 1'b1;
    boundPage = 8'(expCur);
    sendDropped(64, "R2 halted");
    stopMode = 1'b0;

    // free-space gating, both branches of the formula
    hostSet(3);
    boundPage = 8'd8;
    sendDropped(64, "R3 five pages ahead");
    @(negedge clk);
    boundPage = 8'd9;
    begin : six_ahead
      int w1;
      w1 = wrCount;
      @(negedge clk);
      rxValid = 1'b1; rxSof = 1'b1; rxEof = 1'b1; rxData = 8'h02;
      @(negedge clk);
      clearRx();
      repeat (70) @(negedge clk);
      check("R3 six pages ahead accepted", wrCount - w1, 64);
      check("R3 six pages ahead page", int'(curPage), 4);
      expCur = 4;
      irqClr = 1'b1; @(negedge clk); irqClr = 1'b0;
    end
    boundPage = 8'd1;
    sendDropped(64, "R3 wrapped five pages");
    begin : six_wrapped
      int w1;
      boundPage = 8'd2;
      w1 = wrCount;
      @(negedge clk);
      rxValid = 1'b1; rxSof = 1'b1; rxEof = 1'b1; rxData = 8'h02;
      @(negedge clk);
      clearRx();
      repeat (70) @(negedge clk);
      check("R3 wrapped six pages accepted", wrCount - w1, 64);
      check("R3 wrapped six pages page", int'(curPage), 5);
      expCur = 5;
      irqClr = 1'b1; @(negedge clk); irqClr = 1'b0;
    end

    // frame start and host load while busy are both ignored
    sendFrame(5, 3, 1'b1, 1'b1);
    repeat (70) @(negedge clk);
    check("R10 R11 no action after busy stimulus", int'(curPage), expCur);

    // host load together with a frame start
    w0 = wrCount;
    @(negedge clk);
    curPgWrEn = 1'b1; curPgWrData = 8'd6;
    rxValid = 1'b1; rxSof = 1'b1; rxEof = 1'b1; rxData = 8'h10;
    @(negedge clk);
    curPgWrEn = 1'b0;
    clearRx();
    repeat (70) @(negedge clk);
    check("R11 start with host load dropped", wrCount - w0, 0);
    check("R11 host load taken", int'(curPage), 6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule